// File: doc/BRIEF.md
# Flash-Window Mailbox Command Responder

This block is the controller-side engine of a mailbox protocol through which a host processor reaches a flash device over a firmware address window. The host writes a request into the shared mailbox bytes and rings a doorbell. The responder captures the request and decodes the command byte. It answers informational queries and manages one mapped window: it opens read or write windows, closes them and resets the mapping. It forwards dirty-marking and flush work to an external dirty-tracking unit. The responder writes back a parallel response: the echoed sequence number, eleven argument bytes and a response code. It pulses a host doorbell in the same cycle.

The current window is driven out as open flag, type, start block and size, so an address mapper can follow it. A second port pair carries controller events. Events are set from inside the chip and cleared by the host's acknowledge command.

Dirty-tracking requests use a level handshake. The request holds until the unit signals done, or until a timeout counter expires. The unit's error flag becomes a write-error response.

Top module: `mbox_responder`

## Requirements
- R1: After reset no window is open, no request to the dirty unit is active, no response is pulsed and the event byte is zero.
- R2: Each accepted doorbell yields exactly one single-cycle `rsp_valid` pulse whose `rsp_seq` equals request byte 1. A command that needs no dirty-unit work responds on the second rising edge after the edge that samples the doorbell.
- R3: The response code is always 1 (success), 2 (parameter error), 3 (write error), 4 (system error) or 5 (timeout). Command codes outside 1..9 return 2. Argument bytes a command does not define read as zero.
- R4: Command 2 (info) returns the API version in argument byte 0, the default read size in blocks in bytes 1-2 and the default write size in bytes 3-4, both little-endian, and log2 of the block size in byte 5.
- R5: Command 3 (flash info) returns the flash size in bytes in argument bytes 0-3 and the erase granule in bytes in bytes 4-7, both little-endian.
- R6: Commands 4 (read) and 6 (write) take a block offset in argument bytes 0-1 and a requested size in bytes 2-3. On success they return the start block in bytes 0-1 and the actual size in bytes 2-3, with the start equal to the offset. The opened window's type follows the command.
- R7: A requested size of zero opens a window of the default read or write size.
- R8: The window size is clipped so that it ends at or before the last flash block. An offset at or beyond the flash end returns code 2 and leaves no window open, even if a window was open before.
- R9: Only one window exists. A create command replaces a read window with no dirty-unit request. It first flushes an open write window; dirty-unit operation code 2 means flush.
- R10: Command 7 (mark dirty) needs an open write window and a window-relative block (argument bytes 0-1) below the window size, else code 2. It issues dirty-unit operation code 1 with the absolute block (start plus relative) and the byte count from argument bytes 2-5. The response follows the done handshake, with code 3 if the unit reports an error.
- R11: Command 8 (flush) needs an open write window, else code 2. It issues operation 2 at the window's start block and keeps the window open. Command 5 (close) flushes a write window and then closes it, and closes a read window with no request. Command 1 (reset state) closes any window with no request.
- R12: If the dirty unit does not signal done within the timeout limit, the request drops and the response code is 5.
- R13: Bits raised on `evt_set` accumulate in `evt_status`. Command 9 clears the bits named in its argument byte 0. A bit raised in the same cycle as its clear stays set.
- R14: A doorbell arriving while a command is in progress is ignored and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_db | input | 1 | Host doorbell, sampled while idle |
| mbox_in | input | 64 | Mailbox bytes 0..7, byte k at bits 8k+7:8k |
| evt_set | input | 8 | Controller event bits to raise |
| dt_done | input | 1 | Dirty unit completion |
| dt_err | input | 1 | Dirty unit error, valid with done |
| rsp_valid | output | 1 | Response write strobe and host doorbell |
| rsp_seq | output | 8 | Echoed sequence number |
| rsp_args | output | 88 | Response argument bytes, argument k at bits 8k+7:8k |
| rsp_code | output | 8 | Response code |
| evt_status | output | 8 | Controller event byte |
| win_open | output | 1 | A window is mapped |
| win_write | output | 1 | The window is a write window |
| win_start | output | 16 | Window start block |
| win_size | output | 16 | Window size in blocks |
| dt_req | output | 1 | Dirty unit request, held until done or timeout |
| dt_op | output | 2 | 1 mark dirty, 2 flush |
| dt_block | output | 16 | Absolute block of the request |
| dt_len | output | 32 | Byte count for mark dirty |

## Verification
A corrupted window register shows at the `win_*` ports at once. It also shows at the next mark-dirty or flush as a wrong `dt_block` or a wrongly accepted or rejected command. A lost or stale post-flush action shows as a create that fails to open or a close that leaves the window mapped, in the response two cycles after `dt_done`. A decode fault shows in the code or arguments of the very next response. A handshake fault shows as a missing pulse, caught by the response wait limit, or as a second pulse after an ignored doorbell.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int MSG_BYTES = 8;
    localparam int RSP_ARGS  = 11;

    localparam logic [7:0] CMD_RESET     = 8'd1;
    localparam logic [7:0] CMD_MBOX_INFO = 8'd2;
    localparam logic [7:0] CMD_FLASHINFO = 8'd3;
    localparam logic [7:0] CMD_OPEN_RD   = 8'd4;
    localparam logic [7:0] CMD_CLOSE     = 8'd5;
    localparam logic [7:0] CMD_OPEN_WR   = 8'd6;
    localparam logic [7:0] CMD_MARK      = 8'd7;
    localparam logic [7:0] CMD_FLUSH     = 8'd8;
    localparam logic [7:0] CMD_EVT_ACK   = 8'd9;

    localparam logic [7:0] RC_OK      = 8'd1;
    localparam logic [7:0] RC_PARAM   = 8'd2;
    localparam logic [7:0] RC_WRITE   = 8'd3;
    localparam logic [7:0] RC_TIMEOUT = 8'd5;

    typedef enum logic [1:0] {DT_NONE = 2'd0, DT_MARK = 2'd1, DT_FLUSH = 2'd2} dt_op_e;
    typedef enum logic [1:0] {S_IDLE, S_EXEC, S_WAIT, S_DONE} rsp_state_e;
    typedef enum logic [1:0] {P_NONE, P_CLOSE, P_CREATE} post_e;

    typedef struct packed {
        logic        open;
        logic        wr;
        logic [15:0] start;
        logic [15:0] size;
    } window_t;

    function automatic logic [15:0] arg16(input logic [MSG_BYTES*8-1:0] m, input int idx);
        return m[(2+idx)*8 +: 16];
    endfunction

    function automatic logic [31:0] arg32(input logic [MSG_BYTES*8-1:0] m, input int idx);
        return m[(2+idx)*8 +: 32];
    endfunction

endpackage

// File: rtl/mbx_win_calc.sv
module mbx_win_calc #(
    parameter int FLASH_BLKS  = 1024,
    parameter int DEF_RD_BLKS = 32,
    parameter int DEF_WR_BLKS = 8
) (
    input  logic        is_wr,
    input  logic [15:0] offset,
    input  logic [15:0] req_size,
    output logic        ok,
    output logic [15:0] size
);
    localparam logic [16:0] LIMIT = 17'(FLASH_BLKS);
    localparam logic [16:0] DEF_R = 17'(DEF_RD_BLKS);
    localparam logic [16:0] DEF_W = 17'(DEF_WR_BLKS);

    logic [16:0] want;
    logic [16:0] avail;

    always_comb begin
        if (req_size == 16'd0) want = is_wr ? DEF_W : DEF_R;
        else                   want = {1'b0, req_size};
        ok    = {1'b0, offset} < LIMIT;
        avail = LIMIT - {1'b0, offset};
        size  = (want > avail) ? avail[15:0] : want[15:0];
    end
endmodule

// File: rtl/mbx_timer.sv
module mbx_timer #(
    parameter int TMO_CYCLES = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(TMO_CYCLES + 1);
    localparam logic [TW-1:0] LAST = TW'(TMO_CYCLES - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == LAST);
endmodule

// File: rtl/mbox_responder.sv
module mbox_responder
    import mbx_pkg::*;
#(
    parameter int API_VER     = 2,
    parameter int FLASH_BLKS  = 1024,
    parameter int BLK_SHIFT   = 12,
    parameter int ERASE_BYTES = 4096,
    parameter int DEF_RD_BLKS = 32,
    parameter int DEF_WR_BLKS = 8,
    parameter int TMO_CYCLES  = 200
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    host_db,
    input  logic [MSG_BYTES*8-1:0]  mbox_in,
    input  logic [7:0]              evt_set,
    input  logic                    dt_done,
    input  logic                    dt_err,
    output logic                    rsp_valid,
    output logic [7:0]              rsp_seq,
    output logic [RSP_ARGS*8-1:0]   rsp_args,
    output logic [7:0]              rsp_code,
    output logic [7:0]              evt_status,
    output logic                    win_open,
    output logic                    win_write,
    output logic [15:0]             win_start,
    output logic [15:0]             win_size,
    output logic                    dt_req,
    output logic [1:0]              dt_op,
    output logic [15:0]             dt_block,
    output logic [31:0]             dt_len
);
    localparam logic [31:0] FLASH_BYTES = 32'(FLASH_BLKS) << BLK_SHIFT;
    localparam logic [47:0] INFO_ARGS   = {8'(BLK_SHIFT), 16'(DEF_WR_BLKS),
                                           16'(DEF_RD_BLKS), 8'(API_VER)};

    rsp_state_e               st;
    post_e                    post;
    window_t                  win;
    logic [MSG_BYTES*8-1:0]   req_q;
    logic [RSP_ARGS*8-1:0]    args_q;
    logic [7:0]               seq_q, code_q, evt_q;
    dt_op_e                   op_q;
    logic [15:0]              blk_q;
    logic [31:0]              len_q;

    logic [7:0]  cmd;
    logic        wr_open, tmo, cre_ok, is_wr;
    logic [15:0] cre_size, rel;
    window_t     cre_win;
    logic [RSP_ARGS*8-1:0] cre_args;
    logic [7:0]  cre_code;

    assign cmd     = req_q[7:0];
    assign is_wr   = (cmd == CMD_OPEN_WR);
    assign wr_open = win.open && win.wr;
    assign rel     = arg16(req_q, 0);

    mbx_win_calc #(
        .FLASH_BLKS (FLASH_BLKS),
        .DEF_RD_BLKS(DEF_RD_BLKS),
        .DEF_WR_BLKS(DEF_WR_BLKS)
    ) u_calc (
        .is_wr   (is_wr),
        .offset  (arg16(req_q, 0)),
        .req_size(arg16(req_q, 2)),
        .ok      (cre_ok),
        .size    (cre_size)
    );

    mbx_timer #(.TMO_CYCLES(TMO_CYCLES)) u_tmo (
        .clk    (clk),
        .rst    (rst),
        .run    (st == S_WAIT),
        .expired(tmo)
    );

    always_comb begin
        cre_win  = '0;
        cre_args = '0;
        cre_code = RC_PARAM;
        if (cre_ok) begin
            cre_win  = '{open: 1'b1, wr: is_wr, start: arg16(req_q, 0), size: cre_size};
            cre_args[31:0] = {cre_size, arg16(req_q, 0)};
            cre_code = RC_OK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= S_IDLE; post <= P_NONE; win <= '0; req_q <= '0;
            args_q <= '0; seq_q <= '0; code_q <= '0;
            op_q <= DT_NONE; blk_q <= '0; len_q <= '0;
        end else begin
            case (st)
                S_IDLE: if (host_db) begin
                    req_q <= mbox_in;
                    st    <= S_EXEC;
                end
                S_EXEC: begin
                    seq_q  <= req_q[15:8];
                    args_q <= '0;
                    code_q <= RC_OK;
                    post   <= P_NONE;
                    st     <= S_DONE;
                    case (cmd)
                        CMD_RESET:     win <= '0;
                        CMD_MBOX_INFO: args_q[47:0] <= INFO_ARGS;
                        CMD_FLASHINFO: args_q[63:0] <= {32'(ERASE_BYTES), FLASH_BYTES};
                        CMD_OPEN_RD, CMD_OPEN_WR: begin
                            if (wr_open) begin
                                op_q <= DT_FLUSH; blk_q <= win.start; len_q <= '0;
                                post <= P_CREATE; st <= S_WAIT;
                            end else begin
                                win <= cre_win; args_q <= cre_args; code_q <= cre_code;
                            end
                        end
                        CMD_CLOSE: begin
                            if (wr_open) begin
                                op_q <= DT_FLUSH; blk_q <= win.start; len_q <= '0;
                                post <= P_CLOSE; st <= S_WAIT;
                            end else begin
                                win <= '0;
                            end
                        end
                        CMD_MARK: begin
                            if (!wr_open || rel >= win.size) begin
                                code_q <= RC_PARAM;
                            end else begin
                                op_q <= DT_MARK; blk_q <= win.start + rel;
                                len_q <= arg32(req_q, 2); st <= S_WAIT;
                            end
                        end
                        CMD_FLUSH: begin
                            if (!wr_open) begin
                                code_q <= RC_PARAM;
                            end else begin
                                op_q <= DT_FLUSH; blk_q <= win.start; len_q <= '0;
                                st <= S_WAIT;
                            end
                        end
                        CMD_EVT_ACK: ;
                        default: code_q <= RC_PARAM;
                    endcase
                end
                S_WAIT: if (dt_done || tmo) begin
                    st   <= S_DONE;
                    op_q <= DT_NONE;
                    if (!dt_done)    code_q <= RC_TIMEOUT;
                    else if (dt_err) code_q <= RC_WRITE;
                    else             code_q <= RC_OK;
                    if (post == P_CLOSE) begin
                        win <= '0;
                    end else if (post == P_CREATE) begin
                        if (dt_done && !dt_err) begin
                            win <= cre_win; args_q <= cre_args; code_q <= cre_code;
                        end else begin
                            win <= '0;
                        end
                    end
                end
                S_DONE: st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) evt_q <= '0;
        else if (st == S_EXEC && cmd == CMD_EVT_ACK) evt_q <= (evt_q & ~req_q[23:16]) | evt_set;
        else evt_q <= evt_q | evt_set;
    end

    assign rsp_valid  = (st == S_DONE);
    assign rsp_seq    = seq_q;
    assign rsp_args   = args_q;
    assign rsp_code   = code_q;
    assign evt_status = evt_q;
    assign win_open   = win.open;
    assign win_write  = win.wr;
    assign win_start  = win.start;
    assign win_size   = win.size;
    assign dt_req     = (st == S_WAIT);
    assign dt_op      = op_q;
    assign dt_block   = blk_q;
    assign dt_len     = len_q;
endmodule

// File: rtl/mbox_responder_chk.sv
module mbox_responder_chk #(
    parameter int FLASH_BLKS = 1024
) (
    input logic        clk,
    input logic        rst,
    input logic        rsp_valid,
    input logic [7:0]  rsp_code,
    input logic        win_open,
    input logic        win_write,
    input logic [15:0] win_start,
    input logic [15:0] win_size,
    input logic        dt_req,
    input logic        dt_done,
    input logic [1:0]  dt_op,
    input logic [15:0] dt_block,
    input logic [31:0] dt_len
);
    assert_rsp_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_rsp_code_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_code >= 8'd1 && rsp_code <= 8'd5));

    assert_win_type_R6: assert property (@(posedge clk) disable iff (rst)
        win_write |-> win_open);

    assert_win_clip_R8: assert property (@(posedge clk) disable iff (rst)
        win_open |-> (win_size != 16'd0 && ({1'b0, win_start} + {1'b0, win_size}) <= 17'(FLASH_BLKS)));

    assert_dt_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (dt_req && !dt_done) |=> (dt_req || rsp_valid));

    assert_dt_stable_R10: assert property (@(posedge clk) disable iff (rst)
        (dt_req && $past(dt_req)) |-> ($stable(dt_op) && $stable(dt_block) && $stable(dt_len)));

    assert_dt_op_R11: assert property (@(posedge clk) disable iff (rst)
        dt_req |-> (dt_op == 2'd1 || dt_op == 2'd2));

    assert_req_drop_R12: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !dt_req);
endmodule

bind mbox_responder mbox_responder_chk #(.FLASH_BLKS(FLASH_BLKS)) u_chk (
    .clk(clk), .rst(rst), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .win_open(win_open), .win_write(win_write), .win_start(win_start),
    .win_size(win_size), .dt_req(dt_req), .dt_done(dt_done), .dt_op(dt_op),
    .dt_block(dt_block), .dt_len(dt_len)
);

// File: tb/mbox_responder_tb.sv
module mbox_responder_tb;
    localparam int TMO = 200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_db = 1'b0;
    logic [63:0] mbox_in = '0;
    logic [7:0]  evt_set = '0;
    logic        dt_done, dt_err;
    logic        rsp_valid;
    logic [7:0]  rsp_seq, rsp_code, evt_status;
    logic [87:0] rsp_args;
    logic        win_open, win_write, dt_req;
    logic [15:0] win_start, win_size, dt_block;
    logic [1:0]  dt_op;
    logic [31:0] dt_len;

    int errors = 0;
    int checks = 0;

    int          dt_mode = 0;
    int          n_ops = 0;
    logic [1:0]  last_op;
    logic [15:0] last_blk;
    logic [31:0] last_len;

    logic [7:0]  r_code, r_seq;
    logic [87:0] r_args;
    int          r_lat;
    logic        r_got;

    mbox_responder #(.TMO_CYCLES(TMO)) u_dut (
        .clk(clk), .rst(rst), .host_db(host_db), .mbox_in(mbox_in), .evt_set(evt_set),
        .dt_done(dt_done), .dt_err(dt_err), .rsp_valid(rsp_valid), .rsp_seq(rsp_seq),
        .rsp_args(rsp_args), .rsp_code(rsp_code), .evt_status(evt_status),
        .win_open(win_open), .win_write(win_write), .win_start(win_start),
        .win_size(win_size), .dt_req(dt_req), .dt_op(dt_op), .dt_block(dt_block),
        .dt_len(dt_len)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // dirty unit model: done after three cycles of request (mode 0 ok, 1 error, 2 never)
    initial begin
        int cnt = 0;
        logic seen = 1'b0;
        dt_done = 1'b0;
        dt_err  = 1'b0;
        forever begin
            @(negedge clk);
            dt_done = 1'b0;
            dt_err  = 1'b0;
            if (dt_req && !seen) begin
                n_ops++; last_op = dt_op; last_blk = dt_block; last_len = dt_len; seen = 1'b1;
            end
            if (!dt_req) begin seen = 1'b0; cnt = 0; end
            else if (dt_mode == 2) cnt = 0;
            else begin
                cnt++;
                if (cnt == 3) begin dt_done = 1'b1; dt_err = (dt_mode == 1); cnt = 0; end
            end
        end
    end

    task automatic wait_rsp();
        while (!rsp_valid && r_lat < 1000) begin @(negedge clk); r_lat++; end
        r_got  = rsp_valid;
        r_code = rsp_code; r_seq = rsp_seq; r_args = rsp_args;
        if (!r_got) chk("R2 response missing", 64'd0, 64'd1);
    endtask

    task automatic send(input logic [7:0] cmd, input logic [7:0] seq, input logic [47:0] a);
        @(negedge clk);
        mbox_in = {a, seq, cmd};
        host_db = 1'b1;
        @(negedge clk);
        host_db = 1'b0;
        r_lat = 1;
        wait_rsp();
    endtask

    task automatic t_reset();
        chk("R1 win_open", win_open, 0);
        chk("R1 dt_req", dt_req, 0);
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 evt", evt_status, 0);
    endtask

    task automatic t_info();
        send(8'd2, 8'h11, 48'h0);
        chk("R2 latency", r_lat, 2);
        chk("R2 seq echo", r_seq, 8'h11);
        chk("R4 code", r_code, 1);
        chk("R4 args", r_args[63:0], 64'h0000_0C00_0800_2002);
        chk("R3 upper args zero", r_args[87:64], 0);
    endtask

    task automatic t_flash();
        send(8'd3, 8'h22, 48'h0);
        chk("R5 seq", r_seq, 8'h22);
        chk("R5 flash bytes", r_args[31:0], 32'h0040_0000);
        chk("R5 erase bytes", r_args[63:32], 32'd4096);
    endtask

    task automatic t_unknown();
        send(8'd0, 8'h30, 48'h0);
        chk("R3 cmd 0 code", r_code, 2);
        send(8'd10, 8'h31, 48'h0);
        chk("R3 cmd 10 code", r_code, 2);
        chk("R3 cmd 10 seq", r_seq, 8'h31);
    endtask

    task automatic t_create();
        int ops;
        send(8'd4, 8'h40, {16'h0, 16'd4, 16'h0010});
        chk("R6 code", r_code, 1);
        chk("R6 resp start/size", r_args[31:0], {16'd4, 16'h0010});
        chk("R6 win", {win_open, win_write, win_start, win_size}, {2'b10, 16'h0010, 16'd4});
        ops = n_ops;
        send(8'd4, 8'h41, {16'h0, 16'd0, 16'd200});
        chk("R7 default read size", win_size, 32);
        chk("R9 read replace no op", n_ops, ops);
        send(8'd6, 8'h42, {16'h0, 16'd0, 16'd300});
        chk("R7 default write size", r_args[31:16], 8);
        chk("R6 write type", win_write, 1);
        chk("R9 read replace no op 2", n_ops, ops);
    endtask

    task automatic t_clip();
        int ops;
        send(8'd6, 8'h50, {16'h0, 16'd0, 16'd1020});
        chk("R8 clip", win_size, 4);
        ops = n_ops;
        send(8'd4, 8'h51, {16'h0, 16'd4, 16'd1024});
        chk("R9 flush before create", n_ops, ops + 1);
        chk("R9 flush op", last_op, 2);
        chk("R8 beyond code", r_code, 2);
        chk("R8 beyond closed", win_open, 0);
    endtask

    task automatic t_mark();
        send(8'd7, 8'h60, {16'h0, 32'd16, 16'd0});
        chk("R10 no window", r_code, 2);
        send(8'd6, 8'h61, {16'h0, 16'd10, 16'd100});
        send(8'd7, 8'h62, {32'h0001_2345, 16'd3});
        chk("R10 code", r_code, 1);
        chk("R10 op/blk/len", {last_op, last_blk, last_len}, {2'd1, 16'd103, 32'h0001_2345});
        chk("R10 latency via handshake", r_lat > 2, 1);
        send(8'd7, 8'h63, {32'h10, 16'd10});
        chk("R10 out of window", r_code, 2);
        dt_mode = 1;
        send(8'd7, 8'h64, {32'h10, 16'd9});
        dt_mode = 0;
        chk("R10 unit error", r_code, 3);
    endtask

    task automatic t_flush();
        int ops;
        send(8'd8, 8'h70, 48'h0);
        chk("R11 flush code", r_code, 1);
        chk("R11 flush op/blk", {last_op, last_blk}, {2'd2, 16'd100});
        chk("R11 stays open", win_open, 1);
        ops = n_ops;
        send(8'd5, 8'h71, 48'h0);
        chk("R11 close flushes", n_ops, ops + 1);
        chk("R11 closed", win_open, 0);
        send(8'd8, 8'h72, 48'h0);
        chk("R11 flush no window", r_code, 2);
        send(8'd4, 8'h73, {16'h0, 16'd2, 16'd5});
        send(8'd8, 8'h74, 48'h0);
        chk("R11 flush read window", r_code, 2);
        ops = n_ops;
        send(8'd5, 8'h75, 48'h0);
        chk("R11 close read", {win_open, 32'(n_ops)}, {1'b0, 32'(ops)});
        send(8'd6, 8'h76, {16'h0, 16'd2, 16'd5});
        ops = n_ops;
        send(8'd1, 8'h77, 48'h0);
        chk("R11 reset state", {win_open, 32'(n_ops), r_code}, {1'b0, 32'(ops), 8'd1});
    endtask

    task automatic t_timeout();
        send(8'd6, 8'h80, {16'h0, 16'd2, 16'd5});
        dt_mode = 2;
        send(8'd8, 8'h81, 48'h0);
        dt_mode = 0;
        chk("R12 code", r_code, 5);
        chk("R12 waited", r_lat >= TMO, 1);
        @(negedge clk);
        chk("R12 req dropped", dt_req, 0);
    endtask

    task automatic t_event();
        @(negedge clk); evt_set = 8'h05;
        @(negedge clk); evt_set = 8'h02;
        @(negedge clk); evt_set = 8'h00;
        chk("R13 accumulate", evt_status, 8'h07);
        send(8'd9, 8'h90, 48'h05);
        chk("R13 ack clears", evt_status, 8'h02);
        @(negedge clk);
        mbox_in = {48'h02, 8'h91, 8'd9};
        host_db = 1'b1;
        @(negedge clk);
        host_db = 1'b0; evt_set = 8'h02;
        @(negedge clk);
        evt_set = 8'h00;
        r_lat = 2;
        wait_rsp();
        chk("R13 set wins", evt_status, 8'h02);
        send(8'd9, 8'h92, 48'h02);
        chk("R13 cleared", evt_status, 8'h00);
    endtask

    task automatic t_busy();
        int extra = 0;
        dt_mode = 2;
        @(negedge clk);
        mbox_in = {32'h20, 16'd1, 8'h44, 8'd7};
        host_db = 1'b1;
        @(negedge clk); host_db = 1'b0;
        @(negedge clk); @(negedge clk);
        mbox_in = {48'h0, 8'h99, 8'd3};
        host_db = 1'b1;
        @(negedge clk); host_db = 1'b0;
        dt_mode = 0;
        r_lat = 4;
        wait_rsp();
        chk("R14 first seq", r_seq, 8'h44);
        chk("R14 first code", r_code, 1);
        @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            if (rsp_valid) extra++;
            @(negedge clk);
        end
        chk("R14 no second response", extra, 0);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
                $display("Result: errors=%0d of %0d checks", errors, checks + 1);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_info();
        t_flash();
        t_unknown();
        t_create();
        t_clip();
        t_mark();
        t_flush();
        t_timeout();
        t_event();
        t_busy();
        repeat (5) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule